// File: doc/BRIEF.md
# Flow Bucket Hash

This unit turns a flow descriptor into a bucket index for a hashed packet-forwarding table. A 3-bit kind code picks one of three field groups: an IPv4 tuple, an IPv6 tuple or a pair of bridge MAC addresses. The chosen fields are packed into three 32-bit words, which are then combined by a select, rotate and fold mix. The low bits of the result form the index.

A request is presented for one cycle with `in_valid` high. One clock later the unit shows the index, an `out_ok` flag and `out_valid`. Tunnel kinds and unassigned codes are not hashed. For these the index reads all ones and `out_ok` is low, so the table logic can reject the entry.

Top module: `flow_bucket_hash`

## Requirements
- R1: Kind codes are 0 IPv4 routed, 1 IPv4 NAPT, 3 IPv6 3-tuple, 4 IPv6 5-tuple and 7 bridge. For these supported kinds `out_ok` is 1 in the cycle after the request.
- R2: Kind codes 2 (IPv4-in-IPv6 tunnel), 5 (IPv6-in-IPv4 tunnel) and 6 (unassigned) are unsupported. For them `out_ok` is 0 and `out_index` is all ones.
- R3: For kinds 0 and 1, word A is `v4_ports`, word B is `v4_dst` and word C is `v4_src`.
- R4: For kinds 3 and 4, each address is held in 32-bit words, with word i at bits [32i+31:32i]. The three words are:
  - A = src3 ^ dst3 ^ `v6_ports`
  - B = src2 ^ dst2 ^ dst0
  - C = src1 ^ dst1 ^ src0
- R5: For kind 7, the three words are:
  - A = {`mac_src_hi`[15:0], `mac_src_lo`}
  - B = {`mac_dst_lo`, `mac_src_hi`[31:16]}
  - C = `mac_dst_hi`
- R6: The mix runs in four steps:
  - t = (A & B) | (~A & C)
  - t is rotated left by 8 bits
  - t ^= A ^ B ^ C
  - t ^= t >> 16
  
  `out_index` is t[IDX_W-1:0], with IDX_W = 14 by default.
- R7: `out_valid` equals `in_valid` one cycle earlier. `out_index` and `out_ok` then describe that request.
- R8: While `in_valid` is low, `out_index` and `out_ok` keep their last values.
- R9: During reset `out_valid`, `out_ok` and `out_index` are 0.
- R10: Fields outside the selected kind's group have no effect on `out_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_kind | input | 3 | Flow kind code |
| v4_src | input | 32 | IPv4 source address |
| v4_dst | input | 32 | IPv4 destination address |
| v4_ports | input | 32 | IPv4 packed ports word |
| v6_src | input | 128 | IPv6 source address, four words |
| v6_dst | input | 128 | IPv6 destination address, four words |
| v6_ports | input | 32 | IPv6 packed ports word |
| mac_dst_hi | input | 32 | Destination MAC upper field |
| mac_dst_lo | input | 16 | Destination MAC lower field |
| mac_src_hi | input | 32 | Source MAC upper field |
| mac_src_lo | input | 16 | Source MAC lower field |
| out_valid | output | 1 | Result strobe |
| out_ok | output | 1 | Kind was supported |
| out_index | output | IDX_W | Bucket index |

## Verification
Random descriptors of every kind code are checked against a reference packing-and-mix model. Every field group is randomized on each request, so a packing that reads the wrong group or the wrong word lane shows up as a mismatch.

Several directed cases are also used:
- An IPv4 request with only the source address set to 1 expects the known index 257. This isolates the select path and the rotate direction.
- An all-ones ports word expects index 0. This exercises the inversion in the select and the 16-bit fold.
- Tunnel codes and the unassigned code separate the rejection path from the hashed kinds.
- A pair of identical IPv4 requests that differ only in their IPv6 and MAC fields must give the same index.
- Idle cycles between requests show whether the outputs hold.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;
    localparam int KIND_W = 3;
    localparam int WORD_W = 32;

    typedef enum logic [KIND_W-1:0] {
        FK_V4_ROUTE  = 3'd0,
        FK_V4_NAPT   = 3'd1,
        FK_V4_TUNNEL = 3'd2,
        FK_V6_3T     = 3'd3,
        FK_V6_5T     = 3'd4,
        FK_V6_TUNNEL = 3'd5,
        FK_SPARE     = 3'd6,
        FK_BRIDGE    = 3'd7
    } flow_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] c;
    } mix_words_t;
endpackage

// File: rtl/flow_word_pack.sv
module flow_word_pack
    import flow_hash_pkg::*;
(
    input  logic [KIND_W-1:0]   kind,
    input  logic [WORD_W-1:0]   v4_src,
    input  logic [WORD_W-1:0]   v4_dst,
    input  logic [WORD_W-1:0]   v4_ports,
    input  logic [4*WORD_W-1:0] v6_src,
    input  logic [4*WORD_W-1:0] v6_dst,
    input  logic [WORD_W-1:0]   v6_ports,
    input  logic [31:0]         mac_dst_hi,
    input  logic [15:0]         mac_dst_lo,
    input  logic [31:0]         mac_src_hi,
    input  logic [15:0]         mac_src_lo,
    output mix_words_t          words,
    output logic                supported
);
    localparam int LANES = 4;

    logic [WORD_W-1:0] s_lane [LANES];
    logic [WORD_W-1:0] d_lane [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign s_lane[i] = v6_src[i*WORD_W +: WORD_W];
        assign d_lane[i] = v6_dst[i*WORD_W +: WORD_W];
    end

    always_comb begin
        words     = '0;
        supported = 1'b0;
        case (flow_kind_e'(kind))
            FK_V4_ROUTE, FK_V4_NAPT: begin
                words.a   = v4_ports;
                words.b   = v4_dst;
                words.c   = v4_src;
                supported = 1'b1;
            end
            FK_V6_3T, FK_V6_5T: begin
                words.a   = s_lane[3] ^ d_lane[3] ^ v6_ports;
                words.b   = s_lane[2] ^ d_lane[2] ^ d_lane[0];
                words.c   = s_lane[1] ^ d_lane[1] ^ s_lane[0];
                supported = 1'b1;
            end
            FK_BRIDGE: begin
                words.a   = {mac_src_hi[15:0], mac_src_lo};
                words.b   = {mac_dst_lo, mac_src_hi[31:16]};
                words.c   = mac_dst_hi;
                supported = 1'b1;
            end
            default: begin
                words     = '0;
                supported = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/flow_word_mix.sv
module flow_word_mix
    import flow_hash_pkg::*;
#(
    parameter int IDX_W = 14
) (
    input  mix_words_t       words,
    output logic [IDX_W-1:0] idx
);
    localparam int ROT = 8;
    localparam int FOLD = 16;

    logic [WORD_W-1:0] sel;
    logic [WORD_W-1:0] rot;
    logic [WORD_W-1:0] mixed;
    logic [WORD_W-1:0] folded;

    always_comb begin
        sel    = (words.a & words.b) | (~words.a & words.c);
        rot    = {sel[WORD_W-ROT-1:0], sel[WORD_W-1:WORD_W-ROT]};
        mixed  = rot ^ words.a ^ words.b ^ words.c;
        folded = mixed ^ (mixed >> FOLD);
    end

    assign idx = folded[IDX_W-1:0];

    if (IDX_W < WORD_W) begin : g_trim
        logic unused_hi_bits;
        assign unused_hi_bits = ^folded[WORD_W-1:IDX_W];
    end
endmodule

// File: rtl/flow_bucket_hash.sv
module flow_bucket_hash
    import flow_hash_pkg::*;
#(
    parameter int IDX_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          in_kind,
    input  logic [31:0]         v4_src,
    input  logic [31:0]         v4_dst,
    input  logic [31:0]         v4_ports,
    input  logic [127:0]        v6_src,
    input  logic [127:0]        v6_dst,
    input  logic [31:0]         v6_ports,
    input  logic [31:0]         mac_dst_hi,
    input  logic [15:0]         mac_dst_lo,
    input  logic [31:0]         mac_src_hi,
    input  logic [15:0]         mac_src_lo,
    output logic                out_valid,
    output logic                out_ok,
    output logic [IDX_W-1:0]    out_index
);
    localparam logic [IDX_W-1:0] BAD_IDX = {IDX_W{1'b1}};

    typedef struct packed {
        logic             vld;
        logic             ok;
        logic [IDX_W-1:0] idx;
    } res_t;

    mix_words_t       words;
    logic             supported;
    logic [IDX_W-1:0] mix_idx;
    res_t             res_d;
    res_t             res_q;

    flow_word_pack u_pack (
        .kind       (in_kind),
        .v4_src     (v4_src),
        .v4_dst     (v4_dst),
        .v4_ports   (v4_ports),
        .v6_src     (v6_src),
        .v6_dst     (v6_dst),
        .v6_ports   (v6_ports),
        .mac_dst_hi (mac_dst_hi),
        .mac_dst_lo (mac_dst_lo),
        .mac_src_hi (mac_src_hi),
        .mac_src_lo (mac_src_lo),
        .words      (words),
        .supported  (supported)
    );

    flow_word_mix #(.IDX_W(IDX_W)) u_mix (
        .words (words),
        .idx   (mix_idx)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.ok  = supported;
            res_d.idx = supported ? mix_idx : BAD_IDX;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign out_ok    = res_q.ok;
    assign out_index = res_q.idx;
endmodule

// File: rtl/flow_bucket_hash_chk.sv
module flow_bucket_hash_chk #(
    parameter int IDX_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_kind,
    input logic             out_valid,
    input logic             out_ok,
    input logic [IDX_W-1:0] out_index
);
    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R2
    reject_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ok) |-> (&out_index));

    // R2
    tunnel_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_kind == 3'd2 || in_kind == 3'd5 || in_kind == 3'd6)) |=> !out_ok);

    // R1
    bridge_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 3'd7) |=> out_ok);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_index) && $stable(out_ok) && !out_valid));
endmodule

bind flow_bucket_hash flow_bucket_hash_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_kind   (in_kind),
    .out_valid (out_valid),
    .out_ok    (out_ok),
    .out_index (out_index)
);

// File: tb/flow_bucket_hash_test.sv
module flow_bucket_hash_test;
    localparam int IDX_W = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] in_kind = '0;
    logic [31:0] v4_src = '0, v4_dst = '0, v4_ports = '0, v6_ports = '0;
    logic [127:0] v6_src = '0, v6_dst = '0;
    logic [31:0] mac_dst_hi = '0, mac_src_hi = '0;
    logic [15:0] mac_dst_lo = '0, mac_src_lo = '0;
    logic out_valid, out_ok;
    logic [IDX_W-1:0] out_index;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flow_bucket_hash #(.IDX_W(IDX_W)) uut (.*);

    function automatic logic [IDX_W-1:0] ref_mix(logic [31:0] a, logic [31:0] b, logic [31:0] c);
        logic [31:0] t;
        t = (a & b) | (~a & c);
        t = {t[23:0], t[31:24]};
        t = t ^ a ^ b ^ c;
        t = t ^ (t >> 16);
        return t[IDX_W-1:0];
    endfunction

    function automatic logic ref_ok(logic [2:0] k);
        return (k == 0 || k == 1 || k == 3 || k == 4 || k == 7);
    endfunction

    function automatic logic [IDX_W-1:0] ref_idx(logic [2:0] k);
        logic [31:0] a, b, c;
        case (k)
            3'd0, 3'd1: begin a = v4_ports; b = v4_dst; c = v4_src; end
            3'd3, 3'd4: begin
                a = v6_src[127:96] ^ v6_dst[127:96] ^ v6_ports;
                b = v6_src[95:64] ^ v6_dst[95:64] ^ v6_dst[31:0];
                c = v6_src[63:32] ^ v6_dst[63:32] ^ v6_src[31:0];
            end
            3'd7: begin
                a = {mac_src_hi[15:0], mac_src_lo};
                b = {mac_dst_lo, mac_src_hi[31:16]};
                c = mac_dst_hi;
            end
            default: return {IDX_W{1'b1}};
        endcase
        return ref_mix(a, b, c);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic scramble();
        v4_src = $urandom; v4_dst = $urandom; v4_ports = $urandom; v6_ports = $urandom;
        v6_src = {$urandom, $urandom, $urandom, $urandom};
        v6_dst = {$urandom, $urandom, $urandom, $urandom};
        mac_dst_hi = $urandom; mac_src_hi = $urandom;
        mac_dst_lo = 16'($urandom); mac_src_lo = 16'($urandom);
    endtask

    // inputs already set; pulse and check one cycle later, then check hold
    task automatic fire(logic [2:0] k, string req, output logic [IDX_W-1:0] got);
        logic [IDX_W-1:0] e_idx;
        logic e_ok;
        @(negedge clk);
        in_kind = k;
        in_valid = 1'b1;
        e_idx = ref_idx(k);
        e_ok = ref_ok(k);
        @(negedge clk);
        check({req, " R7 valid"}, 32'(out_valid), 32'd1);
        check({req, " R1/R2 ok"}, 32'(out_ok), 32'(e_ok));
        check({req, " index"}, 32'(out_index), 32'(e_idx));
        got = out_index;
        in_valid = 1'b0;
        scramble();
        in_kind = 3'($urandom);
        @(negedge clk);
        check("R8 idle valid", 32'(out_valid), 32'd0);
        check("R8 hold index", 32'(out_index), 32'(e_idx));
        check("R8 hold ok", 32'(out_ok), 32'(e_ok));
    endtask

    initial begin
        void'($urandom(32'd4242));
        #20000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [IDX_W-1:0] got, got2;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R9
        check("R9 reset valid", 32'(out_valid), 32'd0);
        check("R9 reset ok", 32'(out_ok), 32'd0);
        check("R9 reset index", 32'(out_index), 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 directed: source=1 only -> 257
        scramble(); v4_src = 32'd1; v4_dst = 0; v4_ports = 0;
        fire(3'd0, "R6 R3 src1", got);
        check("R6 known 257", 32'(got), 32'd257);
        // R6 directed: ports all ones -> 0
        scramble(); v4_src = 0; v4_dst = 0; v4_ports = 32'hFFFF_FFFF;
        fire(3'd1, "R6 R3 ports1s", got);
        check("R6 known 0", 32'(got), 32'd0);

        // R2 unsupported codes
        scramble(); fire(3'd2, "R2 v4tun", got);
        scramble(); fire(3'd5, "R2 v6tun", got);
        scramble(); fire(3'd6, "R2 spare", got);

        // R4 / R5 directed
        scramble(); fire(3'd3, "R4 v6 3t", got);
        scramble(); fire(3'd4, "R4 v6 5t", got);
        scramble(); fire(3'd7, "R5 bridge", got);

        // R10 other groups ignored
        scramble(); v4_src = 32'h0A00_0001; v4_dst = 32'hC0A8_0101; v4_ports = 32'h1234_0050;
        fire(3'd1, "R10 first", got);
        v4_src = 32'h0A00_0001; v4_dst = 32'hC0A8_0101; v4_ports = 32'h1234_0050;
        fire(3'd1, "R10 second", got2);
        check("R10 same index", 32'(got2), 32'(got));

        // random mix
        for (int i = 0; i < 300; i++) begin
            scramble();
            fire(3'($urandom), "R1 R3 R4 R5 R6 random", got);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule